// File: doc/BRIEF.md
# Chunked Block Copy Engine

The engine copies a run of words from one memory region to another through a single word-wide request/acknowledge port. A start pulse loads a source address, a destination address and a 16-bit word count. The engine then works in chunks. The first chunk takes the odd remainder of the count, and every chunk after it is a full 16 words. Before a chunk changes anything, the engine touches the last source word and the last destination word of that chunk. It writes the destination word back unchanged, so any access fault appears before the chunk modifies memory.

Between chunks the engine samples an interrupt request. If the request is set, the engine parks and shows the advanced source, destination and remaining count on its outputs. Software can restart the engine from exactly those values. One overlap case gets special handling: when the destination is one word above the source, an ascending copy would only smear the first word across the block. The engine detects this at start and runs a cheaper fill instead.

Top module: `blk_copy_engine`

## Requirements
- R1: A start with a count of zero raises `done_o` one cycle later and issues no memory request.
- R2: The first chunk of a run moves ((count-1) mod 16)+1 words, and every later chunk moves exactly 16 words.
- R3: In copy mode each chunk begins with three accesses, in this order: a read of the chunk's last source word, a read of the chunk's last destination word, and a write of that same read data back to that destination word.
- R4: After the probe accesses, copy mode moves each word by a read of source+i followed by a write to destination+i, with i rising from 0. Copy mode makes count+2·chunks reads and count+chunks writes.
- R5: When the destination equals the source plus one (modulo the address width), every chunk makes one read at the current source and then writes that word to each destination word of the chunk. The run makes exactly one read per chunk.
- R6: `irq_i` is sampled only at a chunk boundary, after at least one chunk of the current run has finished and while words remain. When it is high, the engine pulses `halt_o`, goes idle, and shows the advanced source, destination and remaining count. A restart with those values completes the copy.
- R7: At normal completion `done_o` pulses for one cycle, `cnt_o` is 0, and `src_o`/`dst_o` equal the start addresses plus the count.
- R8: A start pulse that arrives while `busy_o` is high has no effect on the running transfer or its results.
- R9: While `mem_req_o` is high and `mem_ack_i` is low, the request, its address, its write-enable and its write data stay unchanged.
- R10: After reset the engine is idle, with no memory request and no done or halt pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, accepted only when idle |
| src_i | input | AW | Start source word address |
| dst_i | input | AW | Start destination word address |
| cnt_i | input | CW | Start word count |
| irq_i | input | 1 | Interrupt request, sampled between chunks |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle pulse when the count reaches zero |
| halt_o | output | 1 | One-cycle pulse when the engine parks on an interrupt |
| src_o | output | AW | Current source address |
| dst_o | output | AW | Current destination address |
| cnt_o | output | CW | Words remaining |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | AW | Access word address |
| mem_wdata_o | output | DW | Write data |
| mem_ack_i | input | 1 | Access complete; read data valid in this cycle |
| mem_rdata_i | input | DW | Read data |

## Verification
The bench uses counts that are multiples of 16 and counts that are not. Only the second kind shows whether the first-chunk remainder is computed correctly, and the probe addresses plus the parking point after an interrupt expose it. The destination is set to the source plus one, to the source plus two, and to unrelated addresses. The access tallies separate the fill path from an ordinary ascending copy, even though the final memory image can match. A held interrupt request is used to stop a run after its first chunk and again after a full 16-word chunk. Each resumed run must leave the same memory as an uninterrupted one. Randomly placed runs with random acknowledge latency, including runs that wrap around the address space, cover address arithmetic and handshake stalls.

// File: rtl/blk_copy_pkg.sv
package blk_copy_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_BOUND, S_PRB_S, S_PRB_D, S_PRB_W,
    S_CP_RD, S_CP_WR, S_FL_RD, S_FL_WR
  } state_e;
endpackage

// File: rtl/blk_chunk_len.sv
module blk_chunk_len #(
  parameter int CW    = 16,
  parameter int CHUNK = 16,
  localparam int LW   = $clog2(CHUNK) + 1
) (
  input  logic [CW-1:0] cnt_i,
  input  logic          first_i,
  output logic [LW-1:0] len_o
);
  logic [CW-1:0] rem;
  // first chunk takes the remainder so later chunks stay full
  assign rem   = (cnt_i - CW'(1)) & CW'(CHUNK - 1);
  assign len_o = first_i ? (LW'(rem) + LW'(1)) : LW'(CHUNK);
endmodule

// File: rtl/blk_overlap_det.sv
module blk_overlap_det #(
  parameter int AW = 16
) (
  input  logic [AW-1:0] src_i,
  input  logic [AW-1:0] dst_i,
  output logic          hit_o
);
  logic [AW-1:0] src_nxt;
  assign src_nxt = src_i + AW'(1);
  assign hit_o   = (dst_i == src_nxt);
endmodule

// File: rtl/blk_copy_engine.sv
module blk_copy_engine
  import blk_copy_pkg::*;
#(
  parameter int AW    = 16,
  parameter int DW    = 16,
  parameter int CW    = 16,
  parameter int CHUNK = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] src_i,
  input  logic [AW-1:0] dst_i,
  input  logic [CW-1:0] cnt_i,
  input  logic          irq_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          halt_o,
  output logic [AW-1:0] src_o,
  output logic [AW-1:0] dst_o,
  output logic [CW-1:0] cnt_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic          mem_ack_i,
  input  logic [DW-1:0] mem_rdata_i
);
  localparam int LW = $clog2(CHUNK) + 1;

  state_e        state_q;
  logic [AW-1:0] src_q, dst_q;
  logic [CW-1:0] cnt_q;
  logic          first_q, fill_q, done_q, halt_q;
  logic [LW-1:0] len_q, idx_q, len_d;
  logic [DW-1:0] data_q;
  logic          ovl;
  logic [AW-1:0] last_off, idx_off;
  logic          last_word;

  blk_chunk_len #(.CW(CW), .CHUNK(CHUNK)) u_len (
    .cnt_i(cnt_q), .first_i(first_q), .len_o(len_d)
  );

  blk_overlap_det #(.AW(AW)) u_ovl (
    .src_i(src_i), .dst_i(dst_i), .hit_o(ovl)
  );

  assign last_off  = AW'(len_q) - AW'(1);
  assign idx_off   = AW'(idx_q);
  assign last_word = (idx_q == len_q - LW'(1));

  always_comb begin
    mem_req_o   = 1'b1;
    mem_we_o    = 1'b0;
    mem_addr_o  = src_q;
    mem_wdata_o = data_q;
    unique case (state_q)
      S_PRB_S: mem_addr_o = src_q + last_off;
      S_PRB_D: mem_addr_o = dst_q + last_off;
      S_PRB_W: begin mem_we_o = 1'b1; mem_addr_o = dst_q + last_off; end
      S_CP_RD: mem_addr_o = src_q + idx_off;
      S_CP_WR: begin mem_we_o = 1'b1; mem_addr_o = dst_q + idx_off; end
      S_FL_RD: mem_addr_o = src_q;
      S_FL_WR: begin mem_we_o = 1'b1; mem_addr_o = dst_q + idx_off; end
      default: mem_req_o = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      src_q   <= '0;
      dst_q   <= '0;
      cnt_q   <= '0;
      first_q <= 1'b0;
      fill_q  <= 1'b0;
      done_q  <= 1'b0;
      halt_q  <= 1'b0;
      len_q   <= '0;
      idx_q   <= '0;
      data_q  <= '0;
    end else begin
      done_q <= 1'b0;
      halt_q <= 1'b0;
      unique case (state_q)
        S_IDLE: if (start_i) begin
          src_q   <= src_i;
          dst_q   <= dst_i;
          cnt_q   <= cnt_i;
          first_q <= 1'b1;
          fill_q  <= ovl;
          if (cnt_i == '0) done_q <= 1'b1;
          else             state_q <= S_BOUND;
        end
        S_BOUND: begin
          if (cnt_q == '0) begin
            done_q  <= 1'b1;
            state_q <= S_IDLE;
          end else if (!first_q && irq_i) begin
            halt_q  <= 1'b1;
            state_q <= S_IDLE;
          end else begin
            len_q   <= len_d;
            idx_q   <= '0;
            state_q <= fill_q ? S_FL_RD : S_PRB_S;
          end
        end
        S_PRB_S: if (mem_ack_i) state_q <= S_PRB_D;
        S_PRB_D: if (mem_ack_i) begin
          data_q  <= mem_rdata_i;
          state_q <= S_PRB_W;
        end
        S_PRB_W: if (mem_ack_i) state_q <= S_CP_RD;
        S_CP_RD, S_FL_RD: if (mem_ack_i) begin
          data_q  <= mem_rdata_i;
          state_q <= (state_q == S_CP_RD) ? S_CP_WR : S_FL_WR;
        end
        S_CP_WR, S_FL_WR: if (mem_ack_i) begin
          if (last_word) begin
            src_q   <= src_q + AW'(len_q);
            dst_q   <= dst_q + AW'(len_q);
            cnt_q   <= cnt_q - CW'(len_q);
            first_q <= 1'b0;
            state_q <= S_BOUND;
          end else begin
            idx_q   <= idx_q + LW'(1);
            state_q <= (state_q == S_CP_WR) ? S_CP_RD : S_FL_WR;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q != S_IDLE);
  assign done_o = done_q;
  assign halt_o = halt_q;
  assign src_o  = src_q;
  assign dst_o  = dst_q;
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/blk_copy_engine_chk.sv
module blk_copy_engine_chk #(
  parameter int AW    = 16,
  parameter int DW    = 16,
  parameter int CW    = 16,
  parameter int CHUNK = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic [AW-1:0] src_i,
  input logic [AW-1:0] dst_i,
  input logic [CW-1:0] cnt_i,
  input logic          irq_i,
  input logic          busy_o,
  input logic          done_o,
  input logic          halt_o,
  input logic [AW-1:0] src_o,
  input logic [AW-1:0] dst_o,
  input logic [CW-1:0] cnt_o,
  input logic          mem_req_o,
  input logic          mem_we_o,
  input logic [AW-1:0] mem_addr_o,
  input logic [DW-1:0] mem_wdata_o,
  input logic          mem_ack_i,
  input logic [DW-1:0] mem_rdata_i
);
  a_r1_zero_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o && cnt_i == '0 |=> done_o && !mem_req_o && !busy_o);

  a_r9_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o)
      && $stable(mem_we_o) && $stable(mem_wdata_o));

  a_r7_done_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> cnt_o == '0 && !busy_o && !halt_o);

  a_r6_halt_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |-> cnt_o != '0 && !busy_o && $past(irq_i));

  a_r10_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_req_o);

  a_r8_busy_keeps_cnt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && start_i && !mem_ack_i |=> $stable(cnt_o) || !busy_o);
endmodule

bind blk_copy_engine blk_copy_engine_chk #(
  .AW(AW), .DW(DW), .CW(CW), .CHUNK(CHUNK)
) u_chk (.*);

// File: tb/blk_copy_engine_bench.sv
module blk_copy_engine_bench;
  localparam int AW = 8, DW = 16, CW = 16, LOGN = 2048;

  logic          clk = 1'b0, rst_n = 1'b1;
  logic          start = 1'b0, irq = 1'b0;
  logic [AW-1:0] src = '0, dst = '0;
  logic [CW-1:0] cnt = '0;
  logic          busy, done, halt, req, we, ack;
  logic [AW-1:0] src_o, dst_o, addr;
  logic [CW-1:0] cnt_o;
  logic [DW-1:0] wdata, rdata;

  logic [DW-1:0] mem [256];
  logic [DW-1:0] ref_mem [256];
  logic [AW-1:0] log_addr [LOGN];
  logic          log_we [LOGN];
  int            log_n = 0, rd_n = 0, wr_n = 0, lat = 0;
  int            n_chk = 0, n_fail = 0;
  bit            got_done, got_halt;

  always #2 clk = ~clk;

  blk_copy_engine #(.AW(AW), .DW(DW), .CW(CW), .CHUNK(16)) u_blk_copy_engine (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .src_i(src), .dst_i(dst),
    .cnt_i(cnt), .irq_i(irq), .busy_o(busy), .done_o(done), .halt_o(halt),
    .src_o(src_o), .dst_o(dst_o), .cnt_o(cnt_o), .mem_req_o(req),
    .mem_we_o(we), .mem_addr_o(addr), .mem_wdata_o(wdata),
    .mem_ack_i(ack), .mem_rdata_i(rdata)
  );

  // memory model: random latency, one access at a time
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack <= 1'b0;
      rdata <= '0;
      for (int i = 0; i < 256; i++) mem[i] <= 16'($urandom);
    end else begin
      ack <= 1'b0;
      if (req && !ack) begin
        if (lat != 0) lat <= lat - 1;
        else begin
          ack <= 1'b1;
          lat <= int'($urandom % 3);
          if (we) begin mem[addr] <= wdata; wr_n <= wr_n + 1; end
          else begin rdata <= mem[addr]; rd_n <= rd_n + 1; end
          log_addr[log_n % LOGN] <= addr;
          log_we[log_n % LOGN]   <= we;
          log_n <= log_n + 1;
        end
      end
    end
  end

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    summary();
  end

  function automatic int first_len(input int n);
    return ((n - 1) % 16) + 1;
  endfunction

  function automatic int chunks(input int n);
    return (n + 15) / 16;
  endfunction

  task automatic snap_ref();
    for (int i = 0; i < 256; i++) ref_mem[i] = mem[i];
  endtask

  task automatic ref_copy(input int s, input int d, input int n);
    for (int i = 0; i < n; i++) ref_mem[(d + i) % 256] = ref_mem[(s + i) % 256];
  endtask

  task automatic chk_mem(input string rq);
    int bad = 0;
    for (int i = 0; i < 256; i++) if (mem[i] !== ref_mem[i]) bad++;
    chk(bad == 0, rq, bad, 0);
  endtask

  task automatic launch(input int s, input int d, input int n);
    @(negedge clk);
    start = 1'b1; src = AW'(s); dst = AW'(d); cnt = CW'(n);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_end();
    int t = 0;
    while (!(done || halt) && t < 20000) begin @(negedge clk); t++; end
    got_done = done;
    got_halt = halt;
  endtask

  // full uninterrupted run with all end checks
  task automatic run_full(input int s, input int d, input int n);
    int r0, w0, ch;
    bit fill;
    fill = (((s + 1) % 256) == d);
    ch = chunks(n);
    snap_ref();
    ref_copy(s, d, n);
    r0 = rd_n; w0 = wr_n;
    launch(s, d, n);
    wait_end();
    chk(got_done, "R7 done pulse", int'(got_done), 1);
    chk(cnt_o == 0, "R7 cnt end", int'(cnt_o), 0);
    chk(src_o == AW'(s + n), "R7 src end", int'(src_o), (s + n) % 256);
    chk(dst_o == AW'(d + n), "R7 dst end", int'(dst_o), (d + n) % 256);
    if (fill) begin
      chk_mem("R5 fill image");
      chk(rd_n - r0 == ch, "R5 reads per chunk", rd_n - r0, ch);
      chk(wr_n - w0 == n, "R5 writes", wr_n - w0, n);
    end else begin
      chk_mem("R4 copy image");
      chk(rd_n - r0 == n + 2 * ch, "R4 reads", rd_n - r0, n + 2 * ch);
      chk(wr_n - w0 == n + ch, "R4 writes", wr_n - w0, n + ch);
    end
  endtask

  initial begin
    int l0, s, d, n, l1, r0;
    void'($urandom(32'd4242));
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R10: idle after reset
    chk(!busy && !req && !done && !halt, "R10 reset idle", int'({busy, req, done, halt}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: zero count
    r0 = rd_n + wr_n;
    launch(7, 9, 0);
    chk(done, "R1 zero done", int'(done), 1);
    repeat (3) @(negedge clk);
    chk(rd_n + wr_n == r0, "R1 no access", rd_n + wr_n - r0, 0);

    // R3/R4: probes then ascending copy, odd first chunk
    l0 = log_n;
    run_full(3, 90, 37);
    l1 = first_len(37);
    chk(!log_we[l0 % LOGN] && log_addr[l0 % LOGN] == AW'(3 + l1 - 1), "R3 probe src",
        int'(log_addr[l0 % LOGN]), 3 + l1 - 1);
    chk(!log_we[(l0 + 1) % LOGN] && log_addr[(l0 + 1) % LOGN] == AW'(90 + l1 - 1), "R3 probe dst",
        int'(log_addr[(l0 + 1) % LOGN]), 90 + l1 - 1);
    chk(log_we[(l0 + 2) % LOGN] && log_addr[(l0 + 2) % LOGN] == AW'(90 + l1 - 1), "R3 probe wb",
        int'(log_addr[(l0 + 2) % LOGN]), 90 + l1 - 1);
    chk(!log_we[(l0 + 3) % LOGN] && log_addr[(l0 + 3) % LOGN] == AW'(3), "R4 first read",
        int'(log_addr[(l0 + 3) % LOGN]), 3);
    chk(log_we[(l0 + 4) % LOGN] && log_addr[(l0 + 4) % LOGN] == AW'(90), "R4 first write",
        int'(log_addr[(l0 + 4) % LOGN]), 90);
    chk(!log_we[(l0 + 5) % LOGN] && log_addr[(l0 + 5) % LOGN] == AW'(4), "R4 second read",
        int'(log_addr[(l0 + 5) % LOGN]), 4);

    // R5: fill overlap, and near-overlap that must copy
    run_full(20, 21, 35);
    run_full(50, 52, 20);
    run_full(255, 0, 40);

    // R6/R2: park after first chunk, again after a full chunk, then finish
    snap_ref();
    irq = 1'b1;
    launch(10, 150, 40);
    wait_end();
    l1 = first_len(40);
    chk(got_halt, "R6 halt pulse", int'(got_halt), 1);
    chk(cnt_o == CW'(40 - l1), "R2 first chunk", int'(cnt_o), 40 - l1);
    chk(src_o == AW'(10 + l1) && dst_o == AW'(150 + l1), "R6 resume ptrs",
        int'(src_o), 10 + l1);
    ref_copy(10, 150, l1);
    chk_mem("R6 partial image");
    launch(int'(src_o), int'(dst_o), int'(cnt_o));
    wait_end();
    chk(got_halt && cnt_o == CW'(40 - l1 - 16), "R2 later chunk 16", int'(cnt_o), 40 - l1 - 16);
    irq = 1'b0;
    launch(int'(src_o), int'(dst_o), int'(cnt_o));
    wait_end();
    ref_copy(10 + l1, 150 + l1, 40 - l1);
    chk(got_done && cnt_o == 0, "R6 resumed done", int'(cnt_o), 0);
    chk_mem("R6 resumed image");

    // R8: start while busy is ignored
    snap_ref();
    ref_copy(30, 120, 50);
    launch(30, 120, 50);
    repeat (20) @(negedge clk);
    chk(busy, "R8 busy", int'(busy), 1);
    start = 1'b1; src = 8'd0; dst = 8'd1; cnt = 16'd5;
    @(negedge clk);
    start = 1'b0;
    wait_end();
    chk(got_done && src_o == AW'(80) && dst_o == AW'(170), "R8 ignored start",
        int'(dst_o), 170);
    chk_mem("R8 image");

    // random runs
    for (int k = 0; k < 14; k++) begin
      s = int'($urandom % 256);
      n = 1 + int'($urandom % 120);
      d = ($urandom % 4 == 0) ? (s + 1) % 256 : int'($urandom % 256);
      run_full(s, d, n);
    end
    run_full(64, 200, 32);
    summary();
  end
endmodule